// File: doc/BRIEF.md
# Masked Requester-ID Lookup Table

This block turns the 16-bit requester ID of a PCI function (bus number, device number, function number) into a stream ID. It holds a fixed set of entries, each pairing a reference requester ID and a don't-care mask with a stream ID and an enable flag. On every clock the lookup port takes one requester ID. One clock later it returns a hit flag, the stream ID of the winning entry and the index of that entry.

Software sets up the entries through a plain 32-bit register port that has write, read, address and data signals. Each entry takes two consecutive words. The even word carries the reference ID and the mask. The odd word carries the enable flag and the stream ID. Reads return what is stored. Unused bits and addresses outside the table read as zero.

Top module: `rid_lut`

## Requirements
- R1: The table has 32 entries. For entry n, the ID/mask word sits at byte address 0x800 + 8·n and the enable/stream word sits at 0x804 + 8·n. Address bits 1:0 are ignored.
- R2: In the ID/mask word, bits 31:16 hold the reference requester ID and bits 15:0 hold the mask. Mask bit k covers requester-ID bit k. Reading the word returns what was written.
- R3: In the enable/stream word, bit 31 is the enable flag and bits 15:0 are the stream ID. Bits 30:16 are not stored and read as zero.
- R4: An enabled entry matches when ((lookup ID XOR reference ID) AND NOT mask) is zero. With a mask of zero, all 16 bits must be equal.
- R5: A disabled entry never matches, whatever its ID and mask hold.
- R6: When more than one entry matches, the result comes from the lowest-numbered matching entry.
- R7: When no entry matches, the hit flag is 0, the stream ID output is 0 and the index output is 0.
- R8: The result appears one clock after the requester ID is presented. A table write is seen by a lookup presented in the cycle after the write, but not by a lookup presented in the same cycle as the write.
- R9: Reset clears and disables every entry, and the lookup outputs read as a miss.
- R10: Reads outside 0x800..0x8FF return zero. Writes outside that range change no entry.
- R11: The requester ID is laid out as bus in bits 15:8, device in bits 7:3 and function in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read data is combinational |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, zero when reg_rd is low |
| lk_id | input | 16 | Requester ID to look up |
| lk_hit | output | 1 | Registered hit flag |
| lk_sid | output | 16 | Registered stream ID of the winning entry |
| lk_idx | output | 5 | Registered index of the winning entry |

## Verification
The bench builds the block with its default parameters: 32 entries, a 16-bit stream ID and a 12-bit address. With these values the bench can program the top entry at 0x8F8/0x8FC and probe the addresses just outside the table on both sides. A write to a low address that shares its low bits with entry 0 shows whether the range decode is incomplete. One test writes an entry in the same cycle that a lookup targets it, which pins down the one-cycle visibility rule of R8.

// File: rtl/rid_lut.sv
module rid_lut #(
  parameter int N_ENT = 32,
  parameter int SID_W = 16,
  parameter int AW    = 12,
  parameter int BASE  = 'h800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [15:0]      lk_id,
  output logic             lk_hit,
  output logic [SID_W-1:0] lk_sid,
  output logic [$clog2(N_ENT)-1:0] lk_idx
);
  localparam int IW = $clog2(N_ENT);
  localparam logic [AW:0] LO = (AW+1)'(BASE);
  localparam logic [AW:0] HI = (AW+1)'(BASE + N_ENT*8);

  logic [15:0]      e_id   [N_ENT];
  logic [15:0]      e_mask [N_ENT];
  logic [SID_W-1:0] e_sid  [N_ENT];
  logic [N_ENT-1:0] e_en;
  logic [N_ENT-1:0] match;

  logic [AW-1:0] off;
  logic          in_rng;
  logic [IW-1:0] sel;

  assign off    = reg_addr - AW'(BASE);
  assign in_rng = ({1'b0, reg_addr} >= LO) && ({1'b0, reg_addr} < HI);
  assign sel    = off[IW+2:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        e_id[i]   <= '0;
        e_mask[i] <= '0;
        e_sid[i]  <= '0;
      end
      e_en <= '0;
    end else if (reg_wr && in_rng) begin
      if (off[2]) begin
        e_en[sel]  <= reg_wdata[31];
        e_sid[sel] <= reg_wdata[SID_W-1:0];
      end else begin
        e_id[sel]   <= reg_wdata[31:16];
        e_mask[sel] <= reg_wdata[15:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd && in_rng) begin
      if (off[2]) reg_rdata = {e_en[sel], {(31-SID_W){1'b0}}, e_sid[sel]};
      else        reg_rdata = {e_id[sel], e_mask[sel]};
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match[g] = e_en[g] && (((lk_id ^ e_id[g]) & ~e_mask[g]) == 16'h0);
  end

  logic             hit_c;
  logic [IW-1:0]    idx_c;
  logic [SID_W-1:0] sid_c;

  always_comb begin
    hit_c = 1'b0;
    idx_c = '0;
    sid_c = '0;
    for (int i = N_ENT-1; i >= 0; i--) begin
      if (match[i]) begin
        hit_c = 1'b1;
        idx_c = i[IW-1:0];
        sid_c = e_sid[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit <= 1'b0;
      lk_sid <= '0;
      lk_idx <= '0;
    end else begin
      lk_hit <= hit_c;
      lk_sid <= sid_c;
      lk_idx <= idx_c;
    end
  end
endmodule

// File: rtl/rid_lut_chk.sv
module rid_lut_chk #(
  parameter int N_ENT = 32,
  parameter int SID_W = 16,
  parameter int AW    = 12,
  parameter int BASE  = 'h800
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_rd,
  input logic [AW-1:0]    reg_addr,
  input logic [31:0]      reg_rdata,
  input logic             lk_hit,
  input logic [SID_W-1:0] lk_sid,
  input logic [$clog2(N_ENT)-1:0] lk_idx
);
  logic in_tab;
  assign in_tab = (int'(reg_addr) >= BASE) && (int'(reg_addr) < BASE + N_ENT*8);

  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_sid == '0 && lk_idx == '0));

  a_r9_reset_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_hit);

  a_r10_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !in_tab) |-> reg_rdata == 32'h0);

  a_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && in_tab && reg_addr[2]) |-> reg_rdata[30:SID_W] == '0);
endmodule

bind rid_lut rid_lut_chk #(.N_ENT(N_ENT), .SID_W(SID_W), .AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .lk_hit(lk_hit), .lk_sid(lk_sid), .lk_idx(lk_idx));

// File: tb/rid_lut_test.sv
`timescale 1ns/1ps
module rid_lut_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] lk_id = '0;
  logic        lk_hit;
  logic [15:0] lk_sid;
  logic [4:0]  lk_idx;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rid_lut uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_id(lk_id), .lk_hit(lk_hit), .lk_sid(lk_sid), .lk_idx(lk_idx));

  function automatic logic [15:0] rid(input int bus, input int dev, input int fn);
    return {bus[7:0], dev[4:0], fn[2:0]}; // R11
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 chk(req, reg_rdata, exp);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic lk_chk(input string req, input logic [15:0] id,
                        input logic h, input logic [15:0] s, input logic [4:0] x);
    @(negedge clk);
    lk_id = id;
    @(negedge clk);
    chk({req, " hit"}, 32'(lk_hit), 32'(h));
    chk({req, " sid"}, 32'(lk_sid), 32'(s));
    chk({req, " idx"}, 32'(lk_idx), 32'(x));
  endtask

  // {id, hit, sid, idx}
  localparam logic [37:0] VEC [8] = '{
    {16'h0108, 1'b1, 16'h0011, 5'd0},  // R6: entries 0 and 1 both match
    {16'h0109, 1'b1, 16'h0022, 5'd1},  // R4 masked low byte
    {16'h01FF, 1'b1, 16'h0022, 5'd1},
    {16'h0205, 1'b1, 16'h0033, 5'd2},  // R4 mask 0x0007
    {16'h0208, 1'b0, 16'h0000, 5'd0},  // R7
    {16'h0300, 1'b0, 16'h0000, 5'd0},  // R5 disabled
    {16'hABCD, 1'b1, 16'h005A, 5'd31}, // R1 top entry
    {16'hABCC, 1'b0, 16'h0000, 5'd0}   // R4 exact with zero mask
  };

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 hit after reset", 32'(lk_hit), 32'h0);
    rd_chk("R9 entry0 id word", 12'h800, 32'h0);
    rd_chk("R9 entry31 en word", 12'h8FC, 32'h0);
    lk_chk("R9 lookup after reset", 16'h0000, 1'b0, 16'h0, 5'd0);

    wr(12'h800, {16'h0108, 16'h0000});
    wr(12'h804, 32'h8000_0011);
    wr(12'h808, {16'h0100, 16'h00FF});
    wr(12'h80C, 32'h8000_0022);
    wr(12'h810, {16'h0200, 16'h0007});
    wr(12'h814, 32'h8000_0033);
    wr(12'h818, {16'h0300, 16'h0000});
    wr(12'h81C, 32'h0000_0044);
    wr(12'h8F8, {16'hABCD, 16'h0000});
    wr(12'h8FC, 32'h8000_005A);

    chk("R11 rid format", 32'(rid(1, 1, 0)), 32'h0108);
    for (int i = 0; i < 8; i++)
      lk_chk($sformatf("R4/R6/R7 vec%0d", i), VEC[i][37:22], VEC[i][21], VEC[i][20:5], VEC[i][4:0]);
    lk_chk("R11 bus2 dev0 fn5", rid(2, 0, 5), 1'b1, 16'h0033, 5'd2);

    rd_chk("R2 id/mask readback", 12'h808, {16'h0100, 16'h00FF});
    rd_chk("R3 en/sid readback", 12'h814, 32'h8000_0033);
    rd_chk("R1 addr bits 1:0 ignored", 12'h80B, {16'h0100, 16'h00FF});
    wr(12'h824, 32'h7FFF_1234);
    rd_chk("R3 pad bits read zero", 12'h824, 32'h0000_1234);

    // R10 out of range
    rd_chk("R10 read below table", 12'h7FC, 32'h0);
    wr(12'h900, 32'hFFFF_FFFF);
    rd_chk("R10 read above table", 12'h900, 32'h0);
    wr(12'h000, {16'h0400, 16'h0000});
    wr(12'h004, 32'h8000_0077);
    rd_chk("R10 alias write ignored", 12'h800, {16'h0108, 16'h0000});
    lk_chk("R10 alias no match", 16'h0400, 1'b0, 16'h0, 5'd0);

    // R8 write visibility
    wr(12'h820, {16'h0500, 16'h0000});
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h824; reg_wdata = 32'h8000_0055; lk_id = 16'h0500;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R8 same-cycle write unseen", 32'(lk_hit), 32'h0);
    @(negedge clk);
    chk("R8 next-cycle hit", 32'(lk_hit), 32'h1);
    chk("R8 next-cycle sid", 32'(lk_sid), 32'h0055);
    chk("R8 next-cycle idx", 32'(lk_idx), 32'd4);

    // R5 disable an entry
    wr(12'h804, 32'h0000_0011);
    lk_chk("R5 disabled entry0 skipped", 16'h0108, 1'b1, 16'h0022, 5'd1);

    // R9 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R9 entry1 cleared", 12'h808, 32'h0);
    lk_chk("R9 lookup misses after reset", 16'h0109, 1'b0, 16'h0, 5'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule